// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside a processor's exception logic and decides, each cycle a dispatch request is raised, whether the pending interrupt level may be taken. Acceptance needs the pending level to exceed the current interrupt level held in the status word, to lie within the configured number of levels, and to have at least one interrupt line that is pending, enabled, and assigned to that level by its mask.

When an interrupt is accepted, the block performs the processor state update in one cycle. A level above 1 saves the program counter and status word into that level's save registers, raises the status interrupt level, and redirects fetch to a per-level vector. A level-1 interrupt becomes a general exception instead. It records a fixed cause code and enters a user, kernel or double-exception vector, chosen from two status bits. Every vector may be relocated through a programmable base register. A vector configured at address zero counts as absent: the state is still saved, but an error strobe replaces the redirect.

Top module: `irq_dispatch`

## Requirements
- R1: With `req_i` high, level L on `pend_lvl_i` is accepted only if L is greater than the current level `ps_i[3:0]`, L is between 1 and NLEVELS, and the level-L mask (bits `(L-1)*NINT` upward of `lvl_mask_i`) ANDed with `int_pend_i` and `int_en_i` is nonzero.
- R2: An accepted level L above 1 writes `pc_i` into the level-L PC save slot (`epc_o` slot L-1) and `ps_i` into the level-L status save slot (`eps_o` slot L-2). It then outputs a status word on `ps_o` equal to `ps_i` with bits [3:0] replaced by L and the exception-mode bit 4 set.
- R3: For a level L above 1 the unrelocated vector is `RST_VECBASE + L*LVL_STRIDE`.
- R4: An accepted level-1 interrupt writes cause code 4 into `exccause_o` and outputs `ps_i` with bit 4 set.
- R5: At level 1 with `ps_i` bit 4 clear, `pc_i` goes to the level-1 PC slot. The vector is `USER_VEC` when `ps_i` bit 5 is set and `KERN_VEC` otherwise.
- R6: At level 1 with `ps_i` bit 4 set, the vector is `DBL_VEC`. The PC goes to `depc_o` when HAS_DEPC is 1, and to the level-1 PC slot otherwise.
- R7: With RELOC_EN set, the fetch target is the vector minus `RST_VECBASE` plus `vecbase_i`.
- R8: All results of an accepted request appear on the outputs at the clock edge that samples it. `taken_o` or `vec_err_o` is high for that one cycle only, unless the next cycle is also accepted.
- R9: If the unrelocated vector is zero, `vec_err_o` pulses instead of `taken_o` and `next_pc_o` keeps its value, while the save registers are still written.
- R10: A request that is not accepted changes no save register, `exccause_o` or `next_pc_o`, and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Dispatch request for the presented pending level |
| pend_lvl_i | input | LW | Highest pending interrupt level |
| pc_i | input | 32 | Program counter of the interrupted instruction |
| ps_i | input | 8 | Status word: [3:0] level, [4] exception mode, [5] user mode |
| int_pend_i | input | NINT | Pending interrupt lines |
| int_en_i | input | NINT | Enabled interrupt lines |
| lvl_mask_i | input | NLEVELS*NINT | Per-level line masks, level L at slice L-1 |
| vecbase_i | input | 32 | Programmable vector base |
| taken_o | output | 1 | One-cycle strobe: interrupt taken and fetch redirected |
| vec_err_o | output | 1 | One-cycle strobe: accepted but vector absent |
| next_pc_o | output | 32 | Redirected fetch address |
| ps_o | output | 8 | Updated status word |
| exccause_o | output | 6 | Exception cause register |
| epc_o | output | NLEVELS*32 | PC save registers, level L at slot L-1 |
| eps_o | output | (NLEVELS-1)*8 | Status save registers, level L at slot L-2 |
| depc_o | output | 32 | Double-exception PC save register |

## Verification
On every cycle, the assertions check these properties. A strobe is only ever preceded by a request whose level exceeded the current level. The two strobes never coincide. Every dispatch sets exception mode, and a high-level dispatch installs its own level in the status word. A level-1 dispatch always leaves cause code 4. A refused request never disturbs the save registers.

Only the bench scenarios can show the rest. These are the exact vector addresses and their relocation against different base values, the user, kernel and double selection, and which save slot receives each PC. They also include the absent-vector error in a configuration without a double-exception PC register.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int ADDR_W  = 32;
  localparam int PS_W    = 8;
  localparam int CAUSE_W = 6;
  localparam logic [PS_W-1:0]    ILVL_MASK  = 8'h0F;
  localparam logic [PS_W-1:0]    EXCM_MASK  = 8'h10;
  localparam logic [PS_W-1:0]    UM_MASK    = 8'h20;
  localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

  typedef enum logic [1:0] {
    ENT_HIGH   = 2'd0,
    ENT_KERNEL = 2'd1,
    ENT_USER   = 2'd2,
    ENT_DOUBLE = 2'd3
  } entry_e;

  // Direct vector of a high-priority level
  function automatic logic [ADDR_W-1:0] lvl_vector(
      input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] stride,
      input logic [ADDR_W-1:0] lvl);
    return base + stride * lvl;
  endfunction

  // Move a configured vector from the reset base onto the live base
  function automatic logic [ADDR_W-1:0] relocate(
      input logic [ADDR_W-1:0] vec, input logic [ADDR_W-1:0] rst_base,
      input logic [ADDR_W-1:0] live_base, input bit en);
    return en ? (vec - rst_base + live_base) : vec;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_dispatch_pkg::*;
#(
  parameter int NLEVELS = 6,
  parameter int NINT    = 16,
  parameter int LW      = 3
) (
  input  logic                    req_i,
  input  logic [LW-1:0]           pend_lvl_i,
  input  logic [3:0]              cur_lvl_i,
  input  logic [NINT-1:0]         int_pend_i,
  input  logic [NINT-1:0]         int_en_i,
  input  logic [NLEVELS*NINT-1:0] lvl_mask_i,
  output logic                    accept_o
);
  logic [NINT-1:0] sel_mask;
  logic            above, in_range, has_line;

  always_comb begin
    sel_mask = '0;
    for (int l = 1; l <= NLEVELS; l++) begin
      if (pend_lvl_i == LW'(l)) sel_mask = lvl_mask_i[(l-1)*NINT +: NINT];
    end
  end

  assign above    = int'(pend_lvl_i) > int'(cur_lvl_i);
  assign in_range = (pend_lvl_i != '0) && (int'(pend_lvl_i) <= NLEVELS);
  assign has_line = |(sel_mask & int_pend_i & int_en_i);
  assign accept_o = req_i && above && in_range && has_line;
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_dispatch_pkg::*;
#(
  parameter int               LW          = 3,
  parameter logic [ADDR_W-1:0] RST_VECBASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] LVL_STRIDE  = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] KERN_VEC    = 32'h4000_0300,
  parameter logic [ADDR_W-1:0] USER_VEC    = 32'h4000_0340,
  parameter logic [ADDR_W-1:0] DBL_VEC     = 32'h4000_03C0,
  parameter bit                RELOC_EN    = 1'b1
) (
  input  logic [LW-1:0]     lvl_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [ADDR_W-1:0] vecbase_i,
  output entry_e            kind_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              absent_o
);
  logic [ADDR_W-1:0] raw_vec;

  always_comb begin
    if (int'(lvl_i) > 1)             kind_o = ENT_HIGH;
    else if ((ps_i & EXCM_MASK) != 0) kind_o = ENT_DOUBLE;
    else if ((ps_i & UM_MASK) != 0)   kind_o = ENT_USER;
    else                              kind_o = ENT_KERNEL;
  end

  always_comb begin
    unique case (kind_o)
      ENT_HIGH:   raw_vec = lvl_vector(RST_VECBASE, LVL_STRIDE, ADDR_W'(lvl_i));
      ENT_USER:   raw_vec = USER_VEC;
      ENT_DOUBLE: raw_vec = DBL_VEC;
      default:    raw_vec = KERN_VEC;
    endcase
  end

  assign absent_o = (raw_vec == '0);
  assign target_o = relocate(raw_vec, RST_VECBASE, vecbase_i, RELOC_EN);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int               NLEVELS     = 6,
  parameter int               NINT        = 16,
  parameter int               LW          = $clog2(NLEVELS + 1),
  parameter logic [ADDR_W-1:0] RST_VECBASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] LVL_STRIDE  = 32'h0000_0040,
  parameter logic [ADDR_W-1:0] KERN_VEC    = 32'h4000_0300,
  parameter logic [ADDR_W-1:0] USER_VEC    = 32'h4000_0340,
  parameter logic [ADDR_W-1:0] DBL_VEC     = 32'h4000_03C0,
  parameter bit                RELOC_EN    = 1'b1,
  parameter bit                HAS_DEPC    = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic [LW-1:0]                pend_lvl_i,
  input  logic [ADDR_W-1:0]            pc_i,
  input  logic [PS_W-1:0]              ps_i,
  input  logic [NINT-1:0]              int_pend_i,
  input  logic [NINT-1:0]              int_en_i,
  input  logic [NLEVELS*NINT-1:0]      lvl_mask_i,
  input  logic [ADDR_W-1:0]            vecbase_i,
  output logic                         taken_o,
  output logic                         vec_err_o,
  output logic [ADDR_W-1:0]            next_pc_o,
  output logic [PS_W-1:0]              ps_o,
  output logic [CAUSE_W-1:0]           exccause_o,
  output logic [NLEVELS*ADDR_W-1:0]    epc_o,
  output logic [(NLEVELS-1)*PS_W-1:0]  eps_o,
  output logic [ADDR_W-1:0]            depc_o
);
  logic              acc_w;
  entry_e            kind_w;
  logic [ADDR_W-1:0] target_w;
  logic              absent_w;

  logic [ADDR_W-1:0] epc_q [1:NLEVELS];
  logic [PS_W-1:0]   eps_q [2:NLEVELS];

  irq_gate #(.NLEVELS(NLEVELS), .NINT(NINT), .LW(LW)) u_gate (
    .req_i      (req_i),
    .pend_lvl_i (pend_lvl_i),
    .cur_lvl_i  (ps_i[3:0]),
    .int_pend_i (int_pend_i),
    .int_en_i   (int_en_i),
    .lvl_mask_i (lvl_mask_i),
    .accept_o   (acc_w)
  );

  irq_vector #(
    .LW(LW), .RST_VECBASE(RST_VECBASE), .LVL_STRIDE(LVL_STRIDE),
    .KERN_VEC(KERN_VEC), .USER_VEC(USER_VEC), .DBL_VEC(DBL_VEC),
    .RELOC_EN(RELOC_EN)
  ) u_vec (
    .lvl_i     (pend_lvl_i),
    .ps_i      (ps_i),
    .vecbase_i (vecbase_i),
    .kind_o    (kind_w),
    .target_o  (target_w),
    .absent_o  (absent_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o    <= 1'b0;
      vec_err_o  <= 1'b0;
      next_pc_o  <= '0;
      ps_o       <= '0;
      exccause_o <= '0;
      depc_o     <= '0;
      for (int l = 1; l <= NLEVELS; l++) epc_q[l] <= '0;
      for (int l = 2; l <= NLEVELS; l++) eps_q[l] <= '0;
    end else begin
      taken_o   <= acc_w && !absent_w;
      vec_err_o <= acc_w && absent_w;
      if (acc_w) begin
        if (!absent_w) next_pc_o <= target_w;
        if (kind_w == ENT_HIGH) begin
          for (int l = 2; l <= NLEVELS; l++) begin
            if (pend_lvl_i == LW'(l)) begin
              epc_q[l] <= pc_i;
              eps_q[l] <= ps_i;
            end
          end
          ps_o <= (ps_i & ~ILVL_MASK) | PS_W'(pend_lvl_i) | EXCM_MASK;
        end else begin
          exccause_o <= CAUSE_LVL1;
          ps_o       <= ps_i | EXCM_MASK;
          if (kind_w == ENT_DOUBLE && HAS_DEPC) depc_o <= pc_i;
          else                                  epc_q[1] <= pc_i;
        end
      end
    end
  end

  for (genvar g = 1; g <= NLEVELS; g++) begin : g_epc
    assign epc_o[(g-1)*ADDR_W +: ADDR_W] = epc_q[g];
  end
  for (genvar g = 2; g <= NLEVELS; g++) begin : g_eps
    assign eps_o[(g-2)*PS_W +: PS_W] = eps_q[g];
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int NLEVELS = 6,
  parameter int LW      = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_i,
  input logic [LW-1:0]             pend_lvl_i,
  input logic [PS_W-1:0]           ps_i,
  input logic                      acc_w,
  input logic                      taken_o,
  input logic                      vec_err_o,
  input logic [PS_W-1:0]           ps_o,
  input logic [CAUSE_W-1:0]        exccause_o,
  input logic [NLEVELS*ADDR_W-1:0] epc_o,
  input logic [ADDR_W-1:0]         depc_o
);
  assert_taken_needs_higher_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o || vec_err_o) |-> ($past(req_i) && int'($past(pend_lvl_i)) > int'($past(ps_i[3:0]))));

  assert_high_level_installed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && int'($past(pend_lvl_i)) > 1) |-> (int'(ps_o[3:0]) == int'($past(pend_lvl_i))));

  assert_lvl1_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((taken_o || vec_err_o) && int'($past(pend_lvl_i)) == 1) |-> (exccause_o == CAUSE_LVL1));

  assert_excm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o || vec_err_o) |-> ((ps_o & EXCM_MASK) != 0));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken_o, vec_err_o}));

  assert_refused_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_w |=> ($stable(epc_o) && $stable(depc_o) && $stable(exccause_o) && !taken_o && !vec_err_o));
endmodule

bind irq_dispatch irq_dispatch_chk #(.NLEVELS(NLEVELS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .pend_lvl_i(pend_lvl_i), .ps_i(ps_i),
  .acc_w(acc_w), .taken_o(taken_o), .vec_err_o(vec_err_o), .ps_o(ps_o),
  .exccause_o(exccause_o), .epc_o(epc_o), .depc_o(depc_o)
);

// File: tb/tb_irq_dispatch.sv
`timescale 1ns/1ps
module tb_irq_dispatch;
  localparam int NL = 6;
  localparam int NI = 16;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req;
  logic [LW-1:0] lvl;
  logic [31:0] pc, vb;
  logic [7:0] ps;
  logic [NI-1:0] ipend, ien;
  logic [NL*NI-1:0] masks;

  logic taken, err, taken2, err2;
  logic [31:0] npc, npc2, depc, depc2;
  logic [7:0] pso, pso2;
  logic [5:0] cause, cause2;
  logic [NL*32-1:0] epc, epc2;
  logic [(NL-1)*8-1:0] eps, eps2;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_dispatch dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pend_lvl_i(lvl), .pc_i(pc), .ps_i(ps),
    .int_pend_i(ipend), .int_en_i(ien), .lvl_mask_i(masks), .vecbase_i(vb),
    .taken_o(taken), .vec_err_o(err), .next_pc_o(npc), .ps_o(pso),
    .exccause_o(cause), .epc_o(epc), .eps_o(eps), .depc_o(depc));

  irq_dispatch #(.DBL_VEC(32'h0), .HAS_DEPC(1'b0)) dut_nodbl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pend_lvl_i(lvl), .pc_i(pc), .ps_i(ps),
    .int_pend_i(ipend), .int_en_i(ien), .lvl_mask_i(masks), .vecbase_i(vb),
    .taken_o(taken2), .vec_err_o(err2), .next_pc_o(npc2), .ps_o(pso2),
    .exccause_o(cause2), .epc_o(epc2), .eps_o(eps2), .depc_o(depc2));

  typedef struct packed {
    logic [2:0]  lv;
    logic [7:0]  ps;
    logic [15:0] ip;
    logic [15:0] en;
    logic [31:0] pc;
    logic        tk;
    logic [31:0] npc;
  } vec_t;

  // vecbase 8000_0000 relocates every vector up by 4000_0000
  localparam vec_t TBL [10] = '{
    '{3'd3, 8'h01, 16'h0010, 16'hFFFF, 32'h1000, 1'b1, 32'h8000_00C0}, // R1 R3 taken
    '{3'd3, 8'h03, 16'h0010, 16'hFFFF, 32'h1004, 1'b0, 32'h0},         // R1 not above
    '{3'd2, 8'h00, 16'h0004, 16'h0000, 32'h1008, 1'b0, 32'h0},         // R1 disabled
    '{3'd7, 8'h00, 16'hFFFF, 16'hFFFF, 32'h100C, 1'b0, 32'h0},         // R1 beyond NLEVELS
    '{3'd6, 8'h05, 16'h0400, 16'h0400, 32'h1010, 1'b1, 32'h8000_0180}, // R3 top level
    '{3'd1, 8'h00, 16'h0001, 16'h0001, 32'h1014, 1'b1, 32'h8000_0300}, // R5 kernel
    '{3'd1, 8'h20, 16'h0002, 16'h0002, 32'h1018, 1'b1, 32'h8000_0340}, // R5 user
    '{3'd1, 8'h10, 16'h0001, 16'hFFFF, 32'h101C, 1'b1, 32'h8000_03C0}, // R6 double
    '{3'd2, 8'h00, 16'h0010, 16'hFFFF, 32'h1020, 1'b0, 32'h0},         // R1 wrong mask
    '{3'd0, 8'h00, 16'hFFFF, 16'hFFFF, 32'h1024, 1'b0, 32'h0}          // R1 level zero
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Drive at negedge, result registered at next posedge, sampled at the following negedge
  task automatic fire(input logic r, input logic [2:0] l, input logic [7:0] p,
                      input logic [15:0] ip, input logic [15:0] en, input logic [31:0] a);
    @(negedge clk);
    req = r; lvl = l; ps = p; ipend = ip; ien = en; pc = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [7:0] exp_ps(input logic [2:0] l, input logic [7:0] p);
    if (l > 1) return {p[7:5], 1'b1, 1'b0, l};
    return p | 8'h10;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_npc, hold2;
    req = 0; lvl = 0; pc = 0; ps = 0; ipend = 0; ien = 0; vb = 32'h8000_0000;
    for (int l = 1; l <= NL; l++) masks[(l-1)*NI +: NI] = 16'h0003 << (2*(l-1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!taken && !err && npc == 0 && cause == 0 && epc == 0 && depc == 0, "R8 reset state",
        {taken, err, cause}, 0);

    last_npc = 0;
    for (int i = 0; i < 10; i++) begin
      fire(1'b1, TBL[i].lv, TBL[i].ps, TBL[i].ip, TBL[i].en, TBL[i].pc);
      chk(taken == TBL[i].tk && !err, "R1 acceptance", taken, TBL[i].tk);
      if (TBL[i].tk) begin
        last_npc = TBL[i].npc;
        chk(pso == exp_ps(TBL[i].lv, TBL[i].ps), "R2 R4 status update", pso, exp_ps(TBL[i].lv, TBL[i].ps));
      end
      chk(npc == last_npc, "R3 R5 R6 R7 R10 fetch target", npc, last_npc);
    end

    chk(epc[2*32 +: 32] == 32'h1000 && eps[1*8 +: 8] == 8'h01, "R2 level3 save", epc[2*32 +: 32], 32'h1000);
    chk(epc[5*32 +: 32] == 32'h1010 && eps[4*8 +: 8] == 8'h05, "R2 level6 save", epc[5*32 +: 32], 32'h1010);
    chk(epc[0 +: 32] == 32'h1018, "R5 level1 pc save", epc[0 +: 32], 32'h1018);
    chk(depc == 32'h101C, "R6 double pc to depc", depc, 32'h101C);
    chk(cause == 6'd4, "R4 cause code", cause, 6'd4);

    // Strobe is one cycle wide
    fire(1'b1, 3'd4, 8'h00, 16'h0040, 16'h0040, 32'h3000);
    chk(taken, "R8 strobe", taken, 1);
    @(negedge clk);
    chk(!taken, "R8 strobe drops", taken, 0);
    chk(epc[3*32 +: 32] == 32'h3000, "R8 save same cycle", epc[3*32 +: 32], 32'h3000);

    // Request low: nothing changes
    fire(1'b0, 3'd5, 8'h00, 16'h0100, 16'h0100, 32'h3100);
    chk(!taken && epc[4*32 +: 32] == 0 && npc == 32'h8000_0100, "R10 no request ignored",
        epc[4*32 +: 32], 0);

    // Relocation against other base values
    vb = 32'h4000_0000;
    fire(1'b1, 3'd2, 8'h00, 16'h0004, 16'h0004, 32'h3200);
    chk(npc == 32'h4000_0080, "R7 base equal reset", npc, 32'h4000_0080);
    vb = 32'h1000_0000;
    fire(1'b1, 3'd2, 8'h01, 16'h0008, 16'h0008, 32'h3204);
    chk(npc == 32'h1000_0080, "R7 lower base", npc, 32'h1000_0080);
    fire(1'b1, 3'd1, 8'h20, 16'h0001, 16'h0001, 32'h3208);
    chk(npc == 32'h1000_0340, "R7 R5 user relocated", npc, 32'h1000_0340);

    // Absent double vector, no depc configured
    hold2 = npc2;
    fire(1'b1, 3'd1, 8'h10, 16'h0001, 16'h0001, 32'h5000);
    chk(err2 && !taken2, "R9 absent vector error", {err2, taken2}, 2'b10);
    chk(npc2 == hold2, "R9 no redirect", npc2, hold2);
    chk(epc2[0 +: 32] == 32'h5000 && depc2 == 0, "R6 no depc uses level1 slot", epc2[0 +: 32], 32'h5000);
    chk(cause2 == 6'd4 && pso2 == 8'h10, "R9 state still written", pso2, 8'h10);
    @(negedge clk);
    chk(!err2, "R8 error strobe drops", err2, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule